// File: doc/BRIEF.md
# Key-Restart Watchdog Timer

This block is a memory-mapped watchdog for a system clock domain. Software programs a timeout range, sets the enable bit, and must then restart the down-counter at intervals by writing a fixed key byte. If the counter reaches zero before that happens, the watchdog responds in one of two ways. It can drive a system reset pulse at once. It can also raise an interrupt first, giving software one further full period to respond before the reset pulse follows.

The bus is a plain single-cycle register port: address, write strobe, read strobe, 32-bit write data, and combinational 32-bit read data. The timeout is a 4-bit range index, and the counter top for index i is 2^(BASE_EXP+i)-1. With the default BASE_EXP of 16, the tops run from 0x0000FFFF up to 0x7FFFFFFF. The reset pulse length is programmable in powers of two.

Top module: `wdt_top`

## Requirements
- R1: Register offsets. Offset 0x00 is control: bit 0 enable, bit 1 response mode, bits 4:2 pulse length n. Offset 0x04 holds the range index in bits 3:0, and its upper write bits are dropped. Offset 0x08 reads the live counter. Offset 0x10 reads the pending interrupt in bit 0. Offsets 0x0C and 0x14 read as 0.
- R2: A write that sets the enable bit while the watchdog is disabled loads the counter with 2^(BASE_EXP+i)-1, where i is the current range index. From then on the counter drops by one every clock.
- R3: Once the enable bit is set, a write of 0 to it has no effect. Only the hardware reset clears it.
- R4: While enabled, a write to 0x0C with 0x76 in bits 7:0 reloads the counter from the current range. Any other byte, or any such write while disabled, leaves the counter unchanged.
- R5: A write to the range register does not change a count in progress. The new range takes effect at the next reload.
- R6: With mode 0, expiry occurs on a clock where the enabled counter is 0. On that clock the counter reloads and the reset pulse starts on the following cycle.
- R7: With mode 1 and no interrupt pending, expiry sets the interrupt, reloads the counter, and does not start a reset pulse.
- R8: With mode 1 and the interrupt still pending, expiry starts the reset pulse.
- R9: A read of 0x14 returns 0 and clears the pending interrupt. After the clear, the next mode-1 expiry again only raises the interrupt.
- R10: The reset output stays high for exactly 2^(n+1) cycles, where n is the 3-bit pulse-length field.
- R11: After reset, every register reads 0, the counter stays at 0 while disabled, and both the interrupt and the reset outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the interrupt at offset 0x14) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| wdt_irq | output | 1 | Pending watchdog interrupt |
| sys_rst_out | output | 1 | Active-high system reset pulse |

## Verification
The checker watches these rules on every clock: the enable bit never falls, the counter decrements by one between loads, every key restart reloads the top of the range, and the interrupt or reset decision is correct on each expiry in either mode. It also checks that a clearing read drops the interrupt. Other behaviour depends on a sequence of bus operations and can only be shown by the bench's scenarios. This covers the exact pulse length, a range change that must wait for the next restart, the rejection of wrong key bytes, and the read-back values of each offset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int DATA_W = 32;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_RANGE = 8'h04;
  localparam logic [7:0] OFS_COUNT = 8'h08;
  localparam logic [7:0] OFS_KICK  = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_ACK   = 8'h14;

  localparam logic [7:0] KICK_KEY = 8'h76;

  localparam int RANGE_W = 4;
  localparam int PLEN_W  = 3;
  localparam int PULSE_W = (1 << PLEN_W) + 1;

  // counter top for a range index: 2^(base+idx)-1
  function automatic logic [63:0] range_top(input int base, input logic [RANGE_W-1:0] idx);
    logic [63:0] one;
    one = 64'd1;
    return (one << (base + int'(idx))) - 64'd1;
  endfunction

  // reset pulse cycles for a length code n: 2^(n+1)
  function automatic logic [PULSE_W-1:0] pulse_cycles(input logic [PLEN_W-1:0] n);
    logic [PULSE_W-1:0] one;
    one = {{(PULSE_W-1){1'b0}}, 1'b1};
    return one << (int'(n) + 1);
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 31
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic                rd,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                irq,
  output logic                en,
  output logic                mode,
  output logic [PLEN_W-1:0]   plen,
  output logic [RANGE_W-1:0]  range_idx,
  output logic                en_rise,
  output logic                kick_hit,
  output logic                ack_rd,
  output logic [DATA_W-1:0]   rdata
);

  logic [7:0] ofs;
  logic sel_ctrl, sel_range, sel_kick;

  assign ofs       = 8'(addr);
  assign sel_ctrl  = wr && (ofs == OFS_CTRL);
  assign sel_range = wr && (ofs == OFS_RANGE);
  assign sel_kick  = wr && (ofs == OFS_KICK);

  assign en_rise  = sel_ctrl && wdata[0] && !en;
  assign kick_hit = sel_kick && en && (wdata[7:0] == KICK_KEY);
  assign ack_rd   = rd && (ofs == OFS_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      mode      <= 1'b0;
      plen      <= '0;
      range_idx <= '0;
    end else begin
      if (sel_ctrl) begin
        en   <= en | wdata[0];
        mode <= wdata[1];
        plen <= wdata[2 +: PLEN_W];
      end
      if (sel_range) range_idx <= wdata[RANGE_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (ofs)
      OFS_CTRL:  rdata = DATA_W'({plen, mode, en});
      OFS_RANGE: rdata = DATA_W'(range_idx);
      OFS_COUNT: rdata = DATA_W'(cnt);
      OFS_STAT:  rdata = DATA_W'(irq);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = 31
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               load,
  input  logic [RANGE_W-1:0] range_idx,
  output logic [CNT_W-1:0]   cnt,
  output logic               expire
);

  logic [CNT_W-1:0] top;

  assign top    = CNT_W'(range_top(BASE_EXP, range_idx));
  assign expire = en && !load && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= top;
    else if (expire)    cnt <= top;
    else if (en)        cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/wdt_respond.sv
module wdt_respond
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              expire,
  input  logic              ack_rd,
  input  logic [PLEN_W-1:0] plen,
  output logic              irq,
  output logic              fire,
  output logic              sys_rst
);

  logic [PULSE_W-1:0] pulse_left;

  assign fire    = expire && (!mode || irq);
  assign sys_rst = (pulse_left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      irq <= 1'b0;
    else if (expire && mode && !irq) irq <= 1'b1;
    else if (ack_rd)                 irq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pulse_left <= '0;
    else if (fire)       pulse_left <= pulse_cycles(plen);
    else if (sys_rst)    pulse_left <= pulse_left - 1'b1;
  end

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BASE_EXP = 16,
  localparam int CNT_W   = BASE_EXP + 15
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_irq,
  output logic              sys_rst_out
);

  logic               en, mode, en_rise, kick_hit, ack_rd, expire, fire;
  logic [PLEN_W-1:0]  plen;
  logic [RANGE_W-1:0] range_idx;
  logic [CNT_W-1:0]   cnt;
  logic               load;

  assign load = en_rise | kick_hit;

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .cnt(cnt), .irq(wdt_irq), .en(en), .mode(mode),
    .plen(plen), .range_idx(range_idx), .en_rise(en_rise),
    .kick_hit(kick_hit), .ack_rd(ack_rd), .rdata(bus_rdata)
  );

  wdt_counter #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load),
    .range_idx(range_idx), .cnt(cnt), .expire(expire)
  );

  wdt_respond u_resp (
    .clk(clk), .rst_n(rst_n), .mode(mode), .expire(expire), .ack_rd(ack_rd),
    .plen(plen), .irq(wdt_irq), .fire(fire), .sys_rst(sys_rst_out)
  );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = 31
)(
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               mode,
  input logic               load,
  input logic               kick_hit,
  input logic               ack_rd,
  input logic               expire,
  input logic               fire,
  input logic               irq,
  input logic               sys_rst,
  input logic [RANGE_W-1:0] range_idx,
  input logic [CNT_W-1:0]   cnt
);

  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  a_r4_key_reload: assert property (@(posedge clk) disable iff (!rst_n)
    kick_hit |=> (cnt == CNT_W'(range_top(BASE_EXP, $past(range_idx)))));

  a_r6_direct_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode) |=> sys_rst);

  a_r7_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode && !irq) |=> (irq && !$past(fire)));

  a_r8_second_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode && irq) |=> sys_rst);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !expire) |=> !irq);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cnt == '0 && !irq));

endmodule

bind wdt_top wdt_checker #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .load(load),
  .kick_hit(kick_hit), .ack_rd(ack_rd), .expire(expire), .fire(fire),
  .irq(wdt_irq), .sys_rst(sys_rst_out), .range_idx(range_idx), .cnt(cnt)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;

  localparam int BASE = 4;
  localparam int NV   = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_irq, sys_rst_out;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  wdt_top #(.ADDR_W(8), .BASE_EXP(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_irq(wdt_irq), .sys_rst_out(sys_rst_out)
  );

  // table: optional write, then a read and its expected value (R1, R4, R11)
  localparam logic       V_DOWR [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [7:0] V_WADR [NV] = '{8'h04, 8'h00, 8'h0C, 8'h04, 8'h00, 8'h00};
  localparam logic [31:0] V_WDAT[NV] = '{32'h2, 32'h14, 32'h76, 32'hFFFF_FFF3, 32'h0, 32'h0};
  localparam logic [7:0] V_RADR [NV] = '{8'h04, 8'h00, 8'h08, 8'h04, 8'h10, 8'h0C};
  localparam logic [31:0] V_EXP [NV] = '{32'h2, 32'h14, 32'h0, 32'h3, 32'h0, 32'h0};

  function automatic logic [31:0] top_of(input int i);
    return (32'd1 << (BASE + i)) - 32'd1;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ack_read(output logic [31:0] d);
    bus_addr = 8'h14; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    tick(50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, c;
    int hi;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R11: reset state
    rd(8'h00, v); check("R11 ctrl", v, 0);
    rd(8'h08, v); check("R11 count", v, 0);
    tick(3);
    rd(8'h08, v); check("R11 idle count", v, 0);
    check("R11 irq", 32'(wdt_irq), 0);
    check("R11 rst", 32'(sys_rst_out), 0);

    // R1 / R4 vector table
    for (int k = 0; k < NV; k++) begin
      if (V_DOWR[k]) wr(V_WADR[k], V_WDAT[k]);
      rd(V_RADR[k], v);
      check($sformatf("R1 vector %0d", k), v, V_EXP[k]);
    end

    // R2: enable loads range 3 top then counts
    wr(8'h00, 32'h15);
    rd(8'h08, v); check("R2 load", v, top_of(3));
    tick(10);
    rd(8'h08, v); check("R2 decrement", v, top_of(3) - 10);

    // R3: enable cannot be cleared
    wr(8'h00, 32'h0C);
    rd(8'h00, v); check("R3 sticky", v, 32'h0D);

    // R4: wrong key ignored, right key reloads
    rd(8'h08, c);
    wr(8'h0C, 32'h75);
    rd(8'h08, v); check("R4 wrong key", v, c - 1);
    wr(8'h0C, 32'h76);
    rd(8'h08, v); check("R4 key reload", v, top_of(3));

    // R5: range change waits for reload
    rd(8'h08, c);
    wr(8'h04, 32'h1);
    rd(8'h08, v); check("R5 no effect", v, c - 1);
    wr(8'h0C, 32'h76);
    rd(8'h08, v); check("R5 new range", v, top_of(1));

    // R6: mode 0 expiry, pulse code 3
    tick(31);
    rd(8'h08, v); check("R6 at zero", v, 0);
    check("R6 no rst yet", 32'(sys_rst_out), 0);
    tick(1);
    check("R6 reset", 32'(sys_rst_out), 1);
    rd(8'h08, v); check("R6 reload", v, top_of(1));
    hi = 0;
    while (sys_rst_out) begin hi++; tick(1); end
    check("R10 pulse n=3", 32'(hi), 16);

    // R7: mode 1 first expiry -> irq only
    wr(8'h00, 32'h03);
    wr(8'h0C, 32'h76);
    tick(32);
    check("R7 irq", 32'(wdt_irq), 1);
    check("R7 no rst", 32'(sys_rst_out), 0);
    rd(8'h10, v); check("R7 status", v, 1);

    // R8: second expiry -> reset
    tick(31);
    check("R8 pending", 32'(sys_rst_out), 0);
    tick(1);
    check("R8 reset", 32'(sys_rst_out), 1);
    hi = 0;
    while (sys_rst_out) begin hi++; tick(1); end
    check("R10 pulse n=0", 32'(hi), 2);

    // R9: clearing read
    ack_read(v); check("R9 ack reads 0", v, 0);
    check("R9 cleared", 32'(wdt_irq), 0);
    wr(8'h0C, 32'h76);
    tick(32);
    check("R9 irq again", 32'(wdt_irq), 1);
    check("R9 no rst", 32'(sys_rst_out), 0);

    finish_run();
  end

endmodule